// File: doc/BRIEF.md
# Ordered Store Buffer

This block sits between one core without caches and a shared memory port. Core stores go into a small queue, and the core moves on without waiting for memory. Queued stores drain to memory in arrival order, with at most one store in flight. The oldest entry leaves the queue only when memory acknowledges it. Because of that, a load can always find every store that memory has not yet confirmed. A load to an address that is still queued is answered from the youngest matching entry and never reaches memory.

A mode input picks the ordering discipline. In relaxed mode a waiting load wins the memory port over queued stores, so loads may overtake stores to other addresses. In sequentially consistent mode the core stalls after each store until that store is acknowledged, and loads block one at a time. Either way the core can request a fence. The fence holds back every later operation until all earlier stores are acknowledged, then signals completion with a one-cycle pulse.

Top module: `wbuf_order_ctrl`

## Requirements
- R1: In relaxed mode (`mode_sc_i`=0), a store is accepted while the queue is not full, and `core_stall_o` stays low afterwards even when memory grants nothing.
- R2: Queued stores reach the memory port in acceptance order, with at most one store in flight. The oldest entry retires only on a `mem_wack_i` pulse.
- R3: The queue holds DEPTH (default 4) stores. `core_stall_o` is high while it is full, and no further operation is accepted.
- R4: In relaxed mode, an accepted load whose address is not queued is presented on the port (`mem_req_o`=1, `mem_we_o`=0) ahead of queued stores that have not yet been sent.
- R5: A load whose address matches a queued store returns the youngest matching data, with `core_rvalid_o` high one cycle after acceptance. No memory request is made for it.
- R6: In sequentially consistent mode (`mode_sc_i`=1), `core_stall_o` rises after a store is accepted. It does not fall before that store's `mem_wack_i` has been seen.
- R7: Loads block. `core_stall_o` is high from load acceptance until `core_rvalid_o`, so at most one load is outstanding. A load served by memory returns `core_rvalid_o` one cycle after `mem_rvalid_i`.
- R8: An accepted fence (`core_fence_i`=1 with `core_req_i`=0) holds `core_stall_o` high until every earlier store is acknowledged. `fence_done_o` then pulses for exactly one cycle.
- R9: Once `mem_req_o` is raised without `mem_gnt_i`, it stays high in the next cycle with `mem_we_o`, `mem_addr_o` and `mem_wdata_o` unchanged.
- R10: After reset, `core_stall_o`, `mem_req_o`, `core_rvalid_o` and `fence_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sc_i | input | 1 | 1 = sequentially consistent, 0 = relaxed |
| core_req_i | input | 1 | Core load or store request |
| core_we_i | input | 1 | 1 = store, 0 = load |
| core_addr_i | input | AW | Core address |
| core_wdata_i | input | DW | Store data |
| core_fence_i | input | 1 | Fence request (with core_req_i low) |
| core_stall_o | output | 1 | Request not accepted this cycle |
| core_rvalid_o | output | 1 | Load data valid pulse |
| core_rdata_o | output | DW | Load data |
| fence_done_o | output | 1 | Fence completion pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a store |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory store data |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_wack_i | input | 1 | Store acknowledgment pulse |
| mem_rvalid_i | input | 1 | Load data valid pulse |
| mem_rdata_i | input | DW | Load data from memory |

## Verification
The hardest state to reach from the ports is a load racing queued stores. The port is free for it only while a store is in flight and its acknowledgment is held back. The memory model in the bench therefore has an adjustable acknowledgment delay. Stretched to tens of cycles, it keeps the first store in flight and its successors queued while loads to both fresh and queued addresses are issued. The load-priority and forwarding paths are then observed on the port directly. A separate phase holds the grant low with the queue full to exercise request holding and the full stall.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RD   = 2'd1,
    SEL_WR   = 2'd2
  } port_sel_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [AW-1:0]     push_addr_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_i,
  input  logic [AW-1:0]     lk_addr_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [AW-1:0]     head_addr_o,
  output logic [DW-1:0]     head_data_o,
  output logic              hit_o,
  output logic [DW-1:0]     hit_data_o
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [AW-1:0]   addr_q [DEPTH];
  logic [DW-1:0]   data_q [DEPTH];
  logic [PTRW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr_q == PTRW'(g)) begin
        addr_q[g] <= push_addr_i;
        data_q[g] <= push_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o      = (cnt_q == CNTW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  // Scan oldest to youngest; the last match wins.
  always_comb begin
    int slot;
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = int'(rd_ptr_q) + i;
      if (slot >= DEPTH) slot = slot - DEPTH;
      if (i < int'(cnt_q) && addr_q[PTRW'(slot)] == lk_addr_i) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[PTRW'(slot)];
      end
    end
  end
endmodule

// File: rtl/wbuf_port_arb.sv
module wbuf_port_arb
  import wbuf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wr_req_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          gnt_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          rd_taken_o,
  output logic          wr_taken_o
);
  port_sel_e sel;
  logic      hold_wr_q;

  // Loads win, except when a store is already on the port waiting for grant.
  always_comb begin
    sel = SEL_NONE;
    if (rd_req_i && !hold_wr_q) sel = SEL_RD;
    else if (wr_req_i)          sel = SEL_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_wr_q <= 1'b0;
    else         hold_wr_q <= (sel == SEL_WR) && !gnt_i;
  end

  assign mem_req_o   = (sel != SEL_NONE);
  assign mem_we_o    = (sel == SEL_WR);
  assign mem_addr_o  = (sel == SEL_WR) ? wr_addr_i : (sel == SEL_RD) ? rd_addr_i : '0;
  assign mem_wdata_o = (sel == SEL_WR) ? wr_data_i : '0;
  assign rd_taken_o  = (sel == SEL_RD) && gnt_i;
  assign wr_taken_o  = (sel == SEL_WR) && gnt_i;
endmodule

// File: rtl/wbuf_order_ctrl.sv
module wbuf_order_ctrl
  import wbuf_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_sc_i,
  input  logic          core_req_i,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic          core_fence_i,
  output logic          core_stall_o,
  output logic          core_rvalid_o,
  output logic [DW-1:0] core_rdata_o,
  output logic          fence_done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_wack_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          full, empty, hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data;
  logic          rd_taken, wr_taken;

  logic          rd_pend_q, rd_out_q, head_sent_q, fence_q;
  logic          rvalid_q, fdone_q;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] rdata_q;

  logic acc, acc_wr, acc_rd, acc_fence, pop;

  assign core_stall_o = rd_pend_q | rd_out_q | fence_q | full | (mode_sc_i & !empty);
  assign acc       = core_req_i & !core_stall_o;
  assign acc_wr    = acc & core_we_i;
  assign acc_rd    = acc & !core_we_i;
  assign acc_fence = core_fence_i & !core_req_i & !core_stall_o;
  assign pop       = mem_wack_i & head_sent_q;

  wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (acc_wr),
    .push_addr_i (core_addr_i),
    .push_data_i (core_wdata_i),
    .pop_i       (pop),
    .lk_addr_i   (core_addr_i),
    .full_o      (full),
    .empty_o     (empty),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .hit_o       (hit),
    .hit_data_o  (hit_data)
  );

  wbuf_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_pend_q),
    .rd_addr_i   (rd_addr_q),
    .wr_req_i    (!empty && !head_sent_q),
    .wr_addr_i   (head_addr),
    .wr_data_i   (head_data),
    .gnt_i       (mem_gnt_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_taken_o  (rd_taken),
    .wr_taken_o  (wr_taken)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q   <= 1'b0;
      rd_out_q    <= 1'b0;
      rd_addr_q   <= '0;
      head_sent_q <= 1'b0;
      fence_q     <= 1'b0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
      fdone_q     <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      fdone_q  <= 1'b0;
      if (acc_rd && hit) begin
        rvalid_q <= 1'b1;
        rdata_q  <= hit_data;
      end else if (acc_rd) begin
        rd_pend_q <= 1'b1;
        rd_addr_q <= core_addr_i;
      end
      if (rd_taken) begin
        rd_pend_q <= 1'b0;
        rd_out_q  <= 1'b1;
      end
      if (rd_out_q && mem_rvalid_i) begin
        rd_out_q <= 1'b0;
        rvalid_q <= 1'b1;
        rdata_q  <= mem_rdata_i;
      end
      if (wr_taken)  head_sent_q <= 1'b1;
      else if (pop)  head_sent_q <= 1'b0;
      if (acc_fence) fence_q <= 1'b1;
      else if (fence_q && empty) begin
        fence_q <= 1'b0;
        fdone_q <= 1'b1;
      end
    end
  end

  assign core_rvalid_o = rvalid_q;
  assign core_rdata_o  = rdata_q;
  assign fence_done_o  = fdone_q;
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_sc_i,
  input logic          core_req_i,
  input logic          core_we_i,
  input logic          core_fence_i,
  input logic          core_stall_o,
  input logic          fence_done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_gnt_i,
  input logic          mem_wack_i,
  input logic          mem_rvalid_i
);
  localparam int QW = $clog2(DEPTH + 1) + 1;

  logic [QW-1:0] wq;
  logic [1:0]    rdo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wq  <= '0;
      rdo <= '0;
    end else begin
      wq  <= wq + QW'(core_req_i && core_we_i && !core_stall_o) - QW'(mem_wack_i);
      rdo <= rdo + 2'(mem_req_o && mem_gnt_i && !mem_we_o) - 2'(mem_rvalid_i);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wq) <= DEPTH);

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |=> !fence_done_o);

  a_r8_fence_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_fence_i && !core_req_i && !core_stall_o |=> core_stall_o);

  a_r7_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && !mem_we_o |-> rdo == 2'd0);

  a_r6_sc_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_sc_i && core_req_i && core_we_i && !core_stall_o |=> core_stall_o);
endmodule

bind wbuf_order_ctrl wbuf_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_sc_i    (mode_sc_i),
  .core_req_i   (core_req_i),
  .core_we_i    (core_we_i),
  .core_fence_i (core_fence_i),
  .core_stall_o (core_stall_o),
  .fence_done_o (fence_done_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_wack_i   (mem_wack_i),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/sim_wbuf_order_ctrl.sv
module sim_wbuf_order_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sc = 1'b0, core_req = 1'b0, core_we = 1'b0, core_fence = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic core_stall, core_rvalid, fence_done;
  logic [DW-1:0] core_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_gnt = 1'b0;
  logic mem_wack, mem_rvalid;
  logic [DW-1:0] mem_rdata;

  always #(CLK_NS/2) clk = ~clk;

  wbuf_order_ctrl #(.AW(AW), .DW(DW), .DEPTH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_sc_i(mode_sc),
    .core_req_i(core_req), .core_we_i(core_we), .core_addr_i(core_addr),
    .core_wdata_i(core_wdata), .core_fence_i(core_fence),
    .core_stall_o(core_stall), .core_rvalid_o(core_rvalid),
    .core_rdata_o(core_rdata), .fence_done_o(fence_done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_wack_i(mem_wack),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, errors = 0;
  int ack_lat = 2, rd_lat = 2;
  int ack_cnt = 0, rd_cnt = 0;
  int wr_grants = 0, wr_acks = 0;
  bit saw_ack = 0;
  logic [AW-1:0] rd_addr_m = '0;
  logic [DW-1:0] mem_m [256];
  logic [DW-1:0] shadow [256];
  logic [AW+DW-1:0] exp_wr [$];
  logic [DW-1:0]    exp_rd [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wack <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      ack_cnt <= 0; rd_cnt <= 0;
    end else begin
      mem_wack <= 1'b0;
      mem_rvalid <= 1'b0;
      if (ack_cnt != 0) begin
        ack_cnt <= ack_cnt - 1;
        if (ack_cnt == 1) mem_wack <= 1'b1;
      end
      if (rd_cnt != 0) begin
        rd_cnt <= rd_cnt - 1;
        if (rd_cnt == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem_m[rd_addr_m];
        end
      end
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          mem_m[mem_addr] <= mem_wdata;
          ack_cnt <= ack_lat;
        end else begin
          rd_cnt <= rd_lat;
          rd_addr_m <= mem_addr;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wack) begin saw_ack = 1; wr_acks++; end
      if (mem_req && mem_gnt && mem_we) begin
        wr_grants++;
        if (exp_wr.size() == 0) chk(0, "R2 unexpected store", {mem_addr, mem_wdata}, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = exp_wr.pop_front();
          chk({mem_addr, mem_wdata} == e, "R2 store order", {mem_addr, mem_wdata}, e);
        end
      end
      if (core_rvalid) begin
        if (exp_rd.size() == 0) chk(0, "R7 unexpected load data", core_rdata, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_rd.pop_front();
          chk(core_rdata == e, "R5/R7 load data", core_rdata, e);
        end
      end
    end
  end

  task automatic core_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (core_stall) @(negedge clk);
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
    if (we) begin
      exp_wr.push_back({a, d});
      shadow[a] = d;
    end else exp_rd.push_back(shadow[a]);
    @(negedge clk);
    core_req = 1'b0;
  endtask

  task automatic fence();
    @(negedge clk);
    while (core_stall) @(negedge clk);
    core_fence = 1'b1;
    @(negedge clk);
    core_fence = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = DW'(i * 7 + 3);
      shadow[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(core_stall == 1'b0, "R10 stall", core_stall, 0);
    chk(mem_req == 1'b0, "R10 mem_req", mem_req, 0);
    chk(core_rvalid == 1'b0, "R10 rvalid", core_rvalid, 0);
    chk(fence_done == 1'b0, "R10 fence_done", fence_done, 0);
    rst_n = 1'b1;

    // relaxed, memory stalled
    core_op(1, 8'h01, 16'h0011);
    core_op(1, 8'h02, 16'h0022);
    core_op(1, 8'h03, 16'h0033);
    chk(core_stall == 1'b0, "R1 no stall after stores", core_stall, 0);
    core_op(1, 8'h04, 16'h0044);
    chk(core_stall == 1'b1, "R3 full stall", core_stall, 1);
    for (int k = 0; k < 3; k++) begin
      chk(mem_req && mem_we && mem_addr == 8'h01, "R9 held store", {mem_req, mem_we, mem_addr}, {2'b11, 8'h01});
      @(negedge clk);
    end
    ack_lat = 2;
    mem_gnt = 1'b1;
    while (exp_wr.size() != 0 || core_stall) @(negedge clk);

    // load priority and forwarding while the head store waits for its ack
    ack_lat = 30;
    core_op(1, 8'h05, 16'h0055);
    core_op(1, 8'h06, 16'h0066);
    core_op(1, 8'h06, 16'h0067);
    core_op(0, 8'h09, 16'h0);
    chk(mem_req && !mem_we && mem_addr == 8'h09, "R4 load first", {mem_req, mem_we, mem_addr}, {2'b10, 8'h09});
    core_op(0, 8'h06, 16'h0);
    chk(mem_req == 1'b0, "R5 no memory request", mem_req, 0);
    chk(core_rvalid && core_rdata == 16'h0067, "R5 youngest data", core_rdata, 16'h0067);

    // fence
    fence();
    chk(core_stall == 1'b1, "R8 fence stall", core_stall, 1);
    while (!fence_done) @(negedge clk);
    chk(wr_acks == wr_grants && exp_wr.size() == 0, "R8 all acked", wr_acks, wr_grants);
    @(negedge clk);
    chk(fence_done == 1'b0, "R8 one-cycle pulse", fence_done, 0);

    // sequentially consistent
    mode_sc = 1'b1;
    ack_lat = 5;
    core_op(1, 8'h0A, 16'h00AA);
    saw_ack = 0;
    chk(core_stall == 1'b1, "R6 stall after store", core_stall, 1);
    while (core_stall) @(negedge clk);
    chk(saw_ack == 1'b1, "R6 released after ack", saw_ack, 1);
    core_op(0, 8'h0A, 16'h0);
    chk(core_stall == 1'b1, "R7 load blocks", core_stall, 1);
    while (core_stall) @(negedge clk);
    core_op(0, 8'h30, 16'h0);
    while (core_stall) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_rd.size() == 0, "R7 all loads returned", exp_rd.size(), 0);
    chk(exp_wr.size() == 0, "R2 all stores seen", exp_wr.size(), 0);
    finish_run();
  end
endmodule